// File: doc/BRIEF.md
# Memory On-Die Termination Selector

This block is the termination-selection logic inside a DRAM device. On every clock edge it decides which of four termination states the data, strobe and mask pins use. The states are off, write termination, nominal termination and park termination. It also presents the 3-bit resistance code of the chosen state and drives the enable of the termination switch. The analog resistor network, the mode-register write path and command decoding are outside the block.

The inputs are three 3-bit resistance fields from the mode registers (nominal, write and park), the external termination pin, decoded write and read command strobes, a self-refresh flag, and the enables for the data-mask mode and the two bus-inversion modes. Each command strobe opens an activity window that lasts `BURST_LEN` cycles. A fixed priority then resolves the choice from the windows, the pin and the fields. The result is registered, so a change takes effect on the clock edge after the inputs that cause it.

Top module: `term_select`

## Requirements
- R1: While `rst_n` is low and right after it is released, `term_state` is 0, `term_on` is 0 and `term_code` is 000.
- R2: When all three fields (`nom_code`, `wr_code`, `park_code`) are 000, `term_on` stays 0 on every cycle.
- R3: When a write window is active, no read window is active, self refresh is off and `wr_code` is non-zero, the next state is write (1) with `term_code` = `wr_code`, whatever the level of `odt_pin`.
- R4: When R3, R6 and R9 do not apply, `odt_pin` is high, `nom_code` is non-zero and nothing is blocked by R8, the next state is nominal (2) with `term_code` = `nom_code`.
- R5: When `nom_code` is 000, `odt_pin` has no effect. A high pin then gives park if `park_code` is non-zero, and off otherwise.
- R6: When `self_ref` is high, the next state is off (0) and `term_on` is 0, even during a write window and even with the pin high.
- R7: When no higher-priority rule applies and `park_code` is non-zero, the next state is park (3) with `term_code` = `park_code`.
- R8: When `dbi_rd_en` is high and both `dm_en` and `dbi_wr_en` are low, the nominal and park states resolve to off. The write state is not affected.
- R9: A read window forces the next state to off. This overrides write, nominal and park.
- R10: A strobe sampled at edge N opens its window. The registered outputs reflect that window at edges N+1 through N+`BURST_LEN`, and no longer at edge N+`BURST_LEN`+1. A strobe that arrives during an open window reloads the full length.
- R11: `term_on` is 1 exactly when `term_state` is non-zero. In the off state `term_code` is 000.
- R12: During a write window with `wr_code` = 000, selection falls through to nominal, then park, then off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nom_code | input | 3 | Nominal termination resistance field |
| wr_code | input | 3 | Write termination resistance field |
| park_code | input | 3 | Park termination resistance field |
| odt_pin | input | 1 | External termination control pin |
| wr_cmd | input | 1 | Decoded write command strobe |
| rd_cmd | input | 1 | Decoded read command strobe |
| self_ref | input | 1 | Device is in self refresh |
| dbi_rd_en | input | 1 | Read bus-inversion mode enabled |
| dbi_wr_en | input | 1 | Write bus-inversion mode enabled |
| dm_en | input | 1 | Data-mask mode enabled |
| term_on | output | 1 | Termination switch enable |
| term_code | output | 3 | Resistance code of the selected state |
| term_state | output | 2 | Selected state: 0 off, 1 write, 2 nominal, 3 park |

## Verification
A write window and a read window can be open in the same cycle, and either can overlap a high termination pin or self refresh. Both strobes are pulsed together and in close succession, during a sweep of the field-zero flags, the pin, self refresh and the bus-inversion block, and again under seeded random traffic. For each cycle the bench keeps its own window counters and computes the expected state and code from the priority order. So when a read and a write coincide, the result is judged against rule R9 beating R3, and self refresh is judged to beat both.

// File: rtl/term_pkg.sv
package term_pkg;
   typedef enum logic [1:0] {
      TS_OFF     = 2'd0,
      TS_WRITE   = 2'd1,
      TS_NOMINAL = 2'd2,
      TS_PARK    = 2'd3
   } term_state_e;
endpackage

// File: rtl/burst_window.sv
module burst_window #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(LEN + 1);
   localparam logic [CW-1:0] LOAD = CW'(LEN);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= LOAD;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign active = (cnt_q != '0);

   a_r10_open: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> active);
   a_r10_close: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && cnt_q == ONE) |=> !active);
endmodule

// File: rtl/term_resolve.sv
module term_resolve
   import term_pkg::*;
#(
   parameter int CODE_W = 3
) (
   input  logic              wr_act,
   input  logic              rd_act,
   input  logic              odt_pin,
   input  logic              self_ref,
   input  logic              dbi_rd_en,
   input  logic              dbi_wr_en,
   input  logic              dm_en,
   input  logic [CODE_W-1:0] nom_code,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [CODE_W-1:0] park_code,
   output term_state_e       sel_state,
   output logic [CODE_W-1:0] sel_code
);
   logic pin_eff;
   logic idle_allowed;

   // pin counts only with a non-zero nominal field and outside self refresh
   assign pin_eff      = odt_pin && (nom_code != '0) && !self_ref;
   assign idle_allowed = !(dbi_rd_en && !(dm_en || dbi_wr_en));

   always_comb begin
      sel_state = TS_OFF;
      sel_code  = '0;
      if (self_ref || rd_act) begin
         sel_state = TS_OFF;
      end else if (wr_act && (wr_code != '0)) begin
         sel_state = TS_WRITE;
         sel_code  = wr_code;
      end else if (pin_eff && idle_allowed) begin
         sel_state = TS_NOMINAL;
         sel_code  = nom_code;
      end else if ((park_code != '0) && idle_allowed) begin
         sel_state = TS_PARK;
         sel_code  = park_code;
      end
   end
endmodule

// File: rtl/term_select.sv
module term_select
   import term_pkg::*;
#(
   parameter int CODE_W    = 3,
   parameter int BURST_LEN = 4,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] nom_code,
   input  logic [CODE_W-1:0] wr_code,
   input  logic [CODE_W-1:0] park_code,
   input  logic              odt_pin,
   input  logic              wr_cmd,
   input  logic              rd_cmd,
   input  logic              self_ref,
   input  logic              dbi_rd_en,
   input  logic              dbi_wr_en,
   input  logic              dm_en,
   output logic              term_on,
   output logic [CODE_W-1:0] term_code,
   output logic [1:0]        term_state
);
   localparam int NWIN = 2;

   if (CODE_W < 1)    begin : g_bad_code  $error("CODE_W must be at least 1");    end
   if (BURST_LEN < 1) begin : g_bad_len   $error("BURST_LEN must be at least 1"); end

   logic [NWIN-1:0] win_start;
   logic [NWIN-1:0] win_act;
   assign win_start = {rd_cmd, wr_cmd};

   for (genvar g = 0; g < NWIN; g++) begin : g_win
      burst_window #(.LEN(BURST_LEN)) u_win (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (win_start[g]),
         .active (win_act[g])
      );
   end

   term_state_e       nxt_state;
   logic [CODE_W-1:0] nxt_code;

   term_resolve #(.CODE_W(CODE_W)) u_resolve (
      .wr_act    (win_act[0]),
      .rd_act    (win_act[1]),
      .odt_pin   (odt_pin),
      .self_ref  (self_ref),
      .dbi_rd_en (dbi_rd_en),
      .dbi_wr_en (dbi_wr_en),
      .dm_en     (dm_en),
      .nom_code  (nom_code),
      .wr_code   (wr_code),
      .park_code (park_code),
      .sel_state (nxt_state),
      .sel_code  (nxt_code)
   );

   if (REG_OUT) begin : g_reg
      logic [1:0]        st_q;
      logic [CODE_W-1:0] cd_q;
      logic              on_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= 2'(TS_OFF);
            cd_q <= '0;
            on_q <= 1'b0;
         end else begin
            st_q <= 2'(nxt_state);
            cd_q <= nxt_code;
            on_q <= (nxt_state != TS_OFF);
         end
      end
      assign term_state = st_q;
      assign term_code  = cd_q;
      assign term_on    = on_q;

      a_r6_selfref_off: assert property (@(posedge clk) disable iff (!rst_n)
         self_ref |=> (!term_on && term_state == 2'd0));
      a_r2_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (nom_code == '0 && wr_code == '0 && park_code == '0) |=> !term_on);
      a_r9_read_off: assert property (@(posedge clk) disable iff (!rst_n)
         win_act[1] |=> term_state == 2'd0);
      a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (win_act[0] && !win_act[1] && !self_ref && wr_code != '0)
            |=> (term_state == 2'd1 && term_code == $past(wr_code)));
      a_r11_off_code: assert property (@(posedge clk) disable iff (!rst_n)
         (term_state == 2'd0) |-> (term_code == '0 && !term_on));
   end else begin : g_comb
      assign term_state = 2'(nxt_state);
      assign term_code  = nxt_code;
      assign term_on    = (nxt_state != TS_OFF);
   end
endmodule

// File: tb/term_select_test.sv
`timescale 1ns/1ps
module term_select_test;
   localparam int BL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] nom_code = '0, wr_code = '0, park_code = '0;
   logic odt_pin = 0, wr_cmd = 0, rd_cmd = 0, self_ref = 0;
   logic dbi_rd_en = 0, dbi_wr_en = 0, dm_en = 0;
   logic term_on;
   logic [2:0] term_code;
   logic [1:0] term_state;

   int n_chk = 0;
   int n_bad = 0;
   int mw = 0;
   int mr = 0;

   always #2.5 clk = ~clk;

   term_select #(.BURST_LEN(BL)) uut (
      .clk(clk), .rst_n(rst_n), .nom_code(nom_code), .wr_code(wr_code),
      .park_code(park_code), .odt_pin(odt_pin), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd),
      .self_ref(self_ref), .dbi_rd_en(dbi_rd_en), .dbi_wr_en(dbi_wr_en),
      .dm_en(dm_en), .term_on(term_on), .term_code(term_code), .term_state(term_state)
   );

   // expected {state, code} from the priority rules
   function automatic logic [4:0] ref_sel(input logic wa, ra, pin, sr, dr, dw, dm,
                                          input logic [2:0] n, w, p);
      logic ok;
      ok = !(dr && !(dm || dw));
      if (sr || ra)                    return {2'd0, 3'd0};
      if (wa && w != 0)                return {2'd1, w};
      if (pin && n != 0 && ok)         return {2'd2, n};
      if (p != 0 && ok)                return {2'd3, p};
      return {2'd0, 3'd0};
   endfunction

   function automatic string tag_of(input logic wa, ra, pin, sr, dr, dw, dm,
                                    input logic [2:0] n, w, p);
      if (sr)                               return "R6";
      if (ra)                               return "R9";
      if (wa && w != 0)                     return "R3";
      if (n == 0 && w == 0 && p == 0)       return "R2";
      if (dr && !(dm || dw))                return "R8";
      if (wa)                               return "R12";
      if (pin && n != 0)                    return "R4";
      if (pin && n == 0)                    return "R5";
      if (p != 0)                           return "R7";
      return "R11";
   endfunction

   task automatic check(input string tag, input logic [4:0] exp);
      logic eon;
      eon = (exp[4:3] != 2'd0);
      n_chk++;
      if (term_state !== exp[4:3] || term_code !== exp[2:0] || term_on !== eon) begin
         n_bad++;
         $display("FAIL %s: state=%0d code=%0d on=%0b expected state=%0d code=%0d on=%0b",
                  tag, term_state, term_code, term_on, exp[4:3], exp[2:0], eon);
      end
   endtask

   // inputs already driven (after a negedge); model and check one edge
   task automatic step(input string force_tag);
      logic [4:0] e;
      string t;
      e = ref_sel(mw != 0, mr != 0, odt_pin, self_ref, dbi_rd_en, dbi_wr_en, dm_en,
                  nom_code, wr_code, park_code);
      t = tag_of(mw != 0, mr != 0, odt_pin, self_ref, dbi_rd_en, dbi_wr_en, dm_en,
                 nom_code, wr_code, park_code);
      if (force_tag != "") t = force_tag;
      if (wr_cmd) mw = BL; else if (mw != 0) mw--;
      if (rd_cmd) mr = BL; else if (mr != 0) mr--;
      @(posedge clk);
      @(negedge clk);
      check(t, e);
   endtask

   task automatic idle();
      wr_cmd = 0; rd_cmd = 0; odt_pin = 0; self_ref = 0;
      dbi_rd_en = 0; dbi_wr_en = 0; dm_en = 0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      int seed;
      seed = $urandom(32'h5EED_0D70);
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", 5'd0);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R1", 5'd0);

      // sweep: field-zero flags, pin, strobes, self refresh, inversion block
      for (int i = 0; i < 256; i++) begin
         nom_code  = i[0] ? 3'd0 : 3'd3;
         wr_code   = i[1] ? 3'd0 : 3'd5;
         park_code = i[2] ? 3'd0 : 3'd6;
         odt_pin   = i[3];
         wr_cmd    = i[4];
         rd_cmd    = i[5];
         self_ref  = i[6];
         dbi_rd_en = i[7];
         dbi_wr_en = 1'b0;
         dm_en     = 1'b0;
         step("");
      end
      idle(); repeat (BL + 1) step("");

      // R10: window length and reload
      nom_code = 3'd2; wr_code = 3'd4; park_code = 3'd1;
      wr_cmd = 1; step("R10"); wr_cmd = 0;
      for (int k = 0; k < BL + 2; k++) step("R10");
      wr_cmd = 1; step("R10"); wr_cmd = 0; step("R10");
      wr_cmd = 1; step("R10"); wr_cmd = 0;
      for (int k = 0; k < BL + 2; k++) step("R10");

      // R9 over R3: simultaneous strobes, then read inside write window
      odt_pin = 1; wr_cmd = 1; rd_cmd = 1; step("R9"); wr_cmd = 0; rd_cmd = 0;
      for (int k = 0; k < BL + 1; k++) step("");
      wr_cmd = 1; step(""); wr_cmd = 0; step("R3");
      rd_cmd = 1; step(""); rd_cmd = 0;
      for (int k = 0; k < BL + 1; k++) step("");

      // R8 relief through data-mask or write inversion
      idle(); dbi_rd_en = 1; odt_pin = 1; step("R8"); step("R8");
      dm_en = 1; step("R4"); step("R4");
      dm_en = 0; dbi_wr_en = 1; odt_pin = 0; step("R7"); step("R7");

      // R5: pin with nominal field zero
      idle(); nom_code = 0; park_code = 3'd7; odt_pin = 1; step("R5"); step("R5");
      park_code = 0; step("R5"); step("R5");

      // R12: write window with zero write field
      nom_code = 3'd3; wr_code = 0; park_code = 3'd2; odt_pin = 1;
      wr_cmd = 1; step(""); wr_cmd = 0; step("R12"); odt_pin = 0; step("R12");
      idle(); repeat (BL) step("");

      // seeded random traffic
      for (int k = 0; k < 4000; k++) begin
         logic [31:0] r;
         r = $urandom;
         nom_code  = (r[1:0] == 0) ? 3'd0 : r[4:2];
         wr_code   = (r[6:5] == 0) ? 3'd0 : r[9:7];
         park_code = (r[11:10] == 0) ? 3'd0 : r[14:12];
         odt_pin   = r[15];
         wr_cmd    = (r[18:16] == 0);
         rd_cmd    = (r[21:19] == 0);
         self_ref  = (r[24:22] == 0);
         dbi_rd_en = r[25];
         dbi_wr_en = r[26] & r[27];
         dm_en     = r[28] & r[29];
         step("");
      end

      finish_run();
   end
endmodule